// File: doc/BRIEF.md
# Host Controller Interrupt Status Bank

This block collects the single-cycle event pulses of a card host controller into one status register and turns them into a single interrupt line. Normal events are command done, transfer done, write-buffer ready, read-buffer ready and card inserted. A parameterised set of error events sits beside them. A status-enable mask decides which incoming events are recorded at all. A separate signal-enable mask decides which recorded bits may raise the interrupt.

Software reaches the bank through a small register bus: a write strobe, a 3-bit word address and 32-bit write data. Read data is combinational on the current address. Status bits are cleared by writing ones. A read-only error summary bit shows whether any error bit is pending, so a driver polling for completion only needs to watch that bit and the command-done bit. A separate 8-bit field records failures of the automatically issued stop command. That field has its own write-one-to-clear register and is not gated by either mask.

Top module: `irq_status_bank`

## Requirements
- R1: After reset, every status bit, both masks, the stop-command error field and `irq_o` are 0.
- R2: An event pulse sets its status bit only when the matching status-enable bit is 1. With that enable bit at 0, the pulse leaves the status unchanged. Status-enable is written and read at address 1, in the same bit layout as the status word.
- R3: A write to address 0 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R4: When an enabled event and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R5: Bit 15 of the status word reads as 1 exactly when any error status bit is set. Writing to it has no effect, and it reads 0 in both mask words.
- R6: `irq_o` is a register. In the cycle after each clock edge it equals the OR over all bits of (status AND signal-enable) as they stood before that edge.
- R7: The signal-enable mask is loaded as a whole at address 2. Writing ones at address 3 sets the selected bits; writing ones at address 4 clears them. Addresses 2, 3 and 4 all read back the mask.
- R8: The signal-enable mask has no influence on which events are recorded. Clearing a status-enable bit does not remove a bit that is already recorded, nor its effect on `irq_o`.
- R9: The 8-bit stop-command error field reads at address 5, bits [7:0]. Each `acmd_err_i` pulse bit sets its bit regardless of both masks, and writing ones there clears the bits written.
- R10: The status word layout is: bit 0 command done, bit 1 transfer done, bit 2 write-buffer ready, bit 3 read-buffer ready, bit 4 card inserted, error event k at bit 16+k. All other bits read 0, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_norm_i | input | NORM_W (5) | Normal event pulses, bit order as in R10 |
| evt_err_i | input | ERR_W (8) | Error event pulses |
| acmd_err_i | input | ACMD_W (8) | Stop-command error pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DW (32) | Register write data |
| reg_rdata_o | output | DW (32) | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt output |

## Verification
An event pulse and a software write-one-to-clear of the same status bit can land in the same clock cycle. The bench provokes this on purpose, once for a normal bit and once for an error bit, and then again at random alongside mask updates. A behavioural reference model resolves each such collision in favour of the event. It also derives the registered interrupt from the state held before the edge. The model is compared with the read data and `irq_o` on every cycle, so a wrong priority or an interrupt that comes one cycle early or late shows up on the cycle it occurs.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SUM_BIT = 15;
  localparam int ERR_LSB = 16;

  localparam logic [2:0] ADDR_STAT    = 3'd0;
  localparam logic [2:0] ADDR_SEN     = 3'd1;
  localparam logic [2:0] ADDR_GEN     = 3'd2;
  localparam logic [2:0] ADDR_GEN_SET = 3'd3;
  localparam logic [2:0] ADDR_GEN_CLR = 3'd4;
  localparam logic [2:0] ADDR_ACMD    = 3'd5;

  typedef enum int {
    EV_CMD_DONE  = 0,
    EV_XFER_DONE = 1,
    EV_WBUF_RDY  = 2,
    EV_RBUF_RDY  = 3,
    EV_CARD_INS  = 4
  } norm_evt_e;
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q_o[i] <= 1'b0;
      else if (set_i[i] && en_i[i]) q_o[i] <= 1'b1;  // event beats clear
      else if (clr_i[i])            q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= data_i;
    else if (set_i)  q_o <= q_o | data_i;
    else if (clr_i)  q_o <= q_o & ~data_i;
  end
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_pkg::*;
#(
  parameter int NORM_W = 5,
  parameter int ERR_W  = 8,
  parameter int ACMD_W = 8,
  parameter int DW     = 32,
  localparam int STAT_W = NORM_W + ERR_W
) (
  input  logic [2:0]        addr_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] sen_i,
  input  logic [STAT_W-1:0] gen_i,
  input  logic [ACMD_W-1:0] acmd_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] stat_w, sen_w, gen_w, acmd_w;

  always_comb begin
    stat_w = '0;
    sen_w  = '0;
    gen_w  = '0;
    acmd_w = '0;
    stat_w[NORM_W-1:0]       = stat_i[NORM_W-1:0];
    stat_w[ERR_LSB +: ERR_W] = stat_i[STAT_W-1:NORM_W];
    stat_w[SUM_BIT]          = |stat_i[STAT_W-1:NORM_W];
    sen_w[NORM_W-1:0]        = sen_i[NORM_W-1:0];
    sen_w[ERR_LSB +: ERR_W]  = sen_i[STAT_W-1:NORM_W];
    gen_w[NORM_W-1:0]        = gen_i[NORM_W-1:0];
    gen_w[ERR_LSB +: ERR_W]  = gen_i[STAT_W-1:NORM_W];
    acmd_w[ACMD_W-1:0]       = acmd_i;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_STAT:                        rdata_o = stat_w;
      ADDR_SEN:                         rdata_o = sen_w;
      ADDR_GEN, ADDR_GEN_SET, ADDR_GEN_CLR: rdata_o = gen_w;
      ADDR_ACMD:                        rdata_o = acmd_w;
      default:                          rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_pkg::*;
#(
  parameter int NORM_W = 5,
  parameter int ERR_W  = 8,
  parameter int ACMD_W = 8,
  parameter int DW     = 32,
  localparam int STAT_W = NORM_W + ERR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NORM_W-1:0] evt_norm_i,
  input  logic [ERR_W-1:0]  evt_err_i,
  input  logic [ACMD_W-1:0] acmd_err_i,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] evt_vec, wd_vec, stat_clr;
  logic [STAT_W-1:0] stat_q, sen_q, gen_q;
  logic [ACMD_W-1:0] acmd_q, acmd_clr;
  logic              wr_stat, wr_sen, wr_gen, wr_gen_set, wr_gen_clr, wr_acmd;
  logic              irq_q;
  logic              unused_wdata;

  assign evt_vec = {evt_err_i, evt_norm_i};
  assign wd_vec  = {reg_wdata_i[ERR_LSB +: ERR_W], reg_wdata_i[NORM_W-1:0]};
  assign unused_wdata = ^{reg_wdata_i[DW-1:ERR_LSB+ERR_W], reg_wdata_i[ERR_LSB-1:NORM_W]};

  assign wr_stat    = reg_wr_i && (reg_addr_i == ADDR_STAT);
  assign wr_sen     = reg_wr_i && (reg_addr_i == ADDR_SEN);
  assign wr_gen     = reg_wr_i && (reg_addr_i == ADDR_GEN);
  assign wr_gen_set = reg_wr_i && (reg_addr_i == ADDR_GEN_SET);
  assign wr_gen_clr = reg_wr_i && (reg_addr_i == ADDR_GEN_CLR);
  assign wr_acmd    = reg_wr_i && (reg_addr_i == ADDR_ACMD);

  assign stat_clr = wr_stat ? wd_vec : '0;
  assign acmd_clr = wr_acmd ? reg_wdata_i[ACMD_W-1:0] : '0;

  irq_mask_reg #(.W(STAT_W)) u_sen (
    .clk_i, .rst_ni,
    .load_i(wr_sen), .set_i(1'b0), .clr_i(1'b0),
    .data_i(wd_vec), .q_o(sen_q)
  );

  irq_mask_reg #(.W(STAT_W)) u_gen (
    .clk_i, .rst_ni,
    .load_i(wr_gen), .set_i(wr_gen_set), .clr_i(wr_gen_clr),
    .data_i(wd_vec), .q_o(gen_q)
  );

  irq_w1c_bank #(.W(STAT_W)) u_stat (
    .clk_i, .rst_ni,
    .set_i(evt_vec), .en_i(sen_q), .clr_i(stat_clr), .q_o(stat_q)
  );

  // stop-command errors are recorded unconditionally
  irq_w1c_bank #(.W(ACMD_W)) u_acmd (
    .clk_i, .rst_ni,
    .set_i(acmd_err_i), .en_i({ACMD_W{1'b1}}), .clr_i(acmd_clr), .q_o(acmd_q)
  );

  irq_readback #(
    .NORM_W(NORM_W), .ERR_W(ERR_W), .ACMD_W(ACMD_W), .DW(DW)
  ) u_rb (
    .addr_i(reg_addr_i), .stat_i(stat_q), .sen_i(sen_q), .gen_i(gen_q),
    .acmd_i(acmd_q), .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_q & gen_q);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk
  import irq_pkg::*;
#(
  parameter int NORM_W = 5,
  parameter int ERR_W  = 8,
  parameter int DW     = 32,
  localparam int STAT_W = NORM_W + ERR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NORM_W-1:0] evt_norm_i,
  input logic [ERR_W-1:0]  evt_err_i,
  input logic              reg_wr_i,
  input logic [2:0]        reg_addr_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic [DW-1:0]     reg_rdata_o,
  input logic              irq_o,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] sen_q,
  input logic [STAT_W-1:0] gen_q
);
  logic [STAT_W-1:0] evt_en, clr_v;
  assign evt_en = {evt_err_i, evt_norm_i} & sen_q;
  assign clr_v  = (reg_wr_i && reg_addr_i == ADDR_STAT) ?
                  {reg_wdata_i[ERR_LSB +: ERR_W], reg_wdata_i[NORM_W-1:0]} : '0;

  p_evt_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(evt_en)) == $past(evt_en)));

  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(~stat_q & ~evt_en)) == '0));

  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_v != '0) |=> ((stat_q & $past(clr_v & ~evt_en)) == '0));

  p_evt_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_v & evt_en) != '0) |=> ((stat_q & $past(clr_v & evt_en)) == $past(clr_v & evt_en)));

  p_summary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_STAT) |-> (reg_rdata_o[SUM_BIT] == |stat_q[STAT_W-1:NORM_W]));

  p_irq_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & gen_q) == '0) |=> !irq_o);

  p_irq_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & gen_q) != '0) |=> irq_o);
endmodule

bind irq_status_bank irq_status_bank_chk #(
  .NORM_W(NORM_W), .ERR_W(ERR_W), .DW(DW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_norm_i(evt_norm_i), .evt_err_i(evt_err_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
  .stat_q(stat_q), .sen_q(sen_q), .gen_q(gen_q)
);

// File: tb/irq_status_bank_tb.sv
module irq_status_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 5;
  localparam int EW = 8;
  localparam int AW8 = 8;
  localparam int SW = NW + EW;
  localparam int WD_CYCLES = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] evt_norm = '0;
  logic [EW-1:0] evt_err = '0;
  logic [7:0]    acmd = '0;
  logic          wr = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int    n_tests = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference model state
  logic [SW-1:0] m_stat, m_sen, m_gen;
  logic [7:0]    m_acmd;
  logic          m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_bank #(.NORM_W(NW), .ERR_W(EW), .ACMD_W(AW8), .DW(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_norm_i(evt_norm), .evt_err_i(evt_err),
    .acmd_err_i(acmd), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [SW-1:0] unpack_w(input logic [31:0] w);
    logic [SW-1:0] v;
    for (int i = 0; i < NW; i++) v[i] = w[i];
    for (int j = 0; j < EW; j++) v[NW+j] = w[16+j];
    return v;
  endfunction

  function automatic logic [31:0] pack_w(input logic [SW-1:0] v);
    logic [31:0] w = '0;
    for (int i = 0; i < NW; i++) w[i] = v[i];
    for (int j = 0; j < EW; j++) w[16+j] = v[NW+j];
    return w;
  endfunction

  function automatic logic [31:0] expect_rd(input logic [2:0] a);
    logic [31:0] w = '0;
    case (a)
      3'd0: begin
        w = pack_w(m_stat);
        w[15] = (m_stat[SW-1:NW] != '0);
      end
      3'd1: w = pack_w(m_sen);
      3'd2, 3'd3, 3'd4: w = pack_w(m_gen);
      3'd5: w = {24'd0, m_acmd};
      default: w = '0;
    endcase
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = '0; m_sen = '0; m_gen = '0; m_acmd = '0; m_irq = 1'b0;
    end else begin
      logic          nxt_irq;
      logic [SW-1:0] ev, wv;
      nxt_irq = 1'b0;
      for (int i = 0; i < SW; i++) if (m_stat[i] && m_gen[i]) nxt_irq = 1'b1;
      ev = {evt_err, evt_norm};
      wv = unpack_w(wdata);
      for (int i = 0; i < SW; i++) begin
        if (ev[i] && m_sen[i]) m_stat[i] = 1'b1;
        else if (wr && addr == 3'd0 && wv[i]) m_stat[i] = 1'b0;
      end
      for (int k = 0; k < 8; k++) begin
        if (acmd[k]) m_acmd[k] = 1'b1;
        else if (wr && addr == 3'd5 && wdata[k]) m_acmd[k] = 1'b0;
      end
      if (wr) begin
        case (addr)
          3'd1: m_sen = wv;
          3'd2: m_gen = wv;
          3'd3: m_gen = m_gen | wv;
          3'd4: m_gen = m_gen & ~wv;
          default: ;
        endcase
      end
      m_irq = nxt_irq;
    end
  end

  task automatic compare();
    logic [31:0] exp_rd;
    exp_rd = expect_rd(addr);
    n_tests++;
    if (rdata !== exp_rd) begin
      n_fail++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, addr, rdata, exp_rd);
    end
    n_tests++;
    if (irq !== m_irq) begin
      n_fail++;
      $display("FAIL %s/R6 irq actual=%b expected=%b", tag, irq, m_irq);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
    wr = 1'b0; evt_norm = '0; evt_err = '0; acmd = '0;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
  endtask

  task automatic do_read(input logic [2:0] a);
    addr = a;
    step();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired during %s", tag);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    // R1: reset values on every address
    tag = "R1";
    for (int a = 0; a < 8; a++) do_read(3'(a));

    // R2: disabled events are ignored
    tag = "R2";
    addr = 3'd0; evt_norm = 5'h1F; evt_err = 8'hFF; step();
    do_read(3'd0);
    do_write(3'd1, 32'h00FF_001F);
    addr = 3'd0; evt_norm = 5'h03; step();
    do_write(3'd1, 32'h0000_0001);
    addr = 3'd0; evt_norm = 5'h06; step();

    // R10: card insert bit position and layout
    tag = "R10";
    do_write(3'd1, 32'h00FF_001F);
    addr = 3'd0; evt_norm = 5'h10; step();
    addr = 3'd0; evt_err = 8'h80; step();
    do_read(3'd6);
    do_read(3'd7);

    // R3: W1C, zeros leave bits alone
    tag = "R3";
    do_write(3'd0, 32'h0000_0000);
    do_write(3'd0, 32'h0000_0001);
    do_write(3'd0, 32'hFFFF_FFFF);

    // R4: event beats clear, normal and error bit
    tag = "R4";
    evt_norm = 5'h04; do_write(3'd0, 32'h0000_0004);
    evt_err = 8'h02; do_write(3'd0, 32'h0002_0004);
    do_write(3'd0, 32'hFFFF_FFFF);

    // R5: summary bit follows error bits, read-only
    tag = "R5";
    addr = 3'd0; evt_err = 8'h21; step();
    do_write(3'd0, 32'h0000_8000);
    do_write(3'd0, 32'h0001_0000);
    do_write(3'd0, 32'h0020_0000);
    do_write(3'd1, 32'hFFFF_FFFF);
    do_read(3'd1);

    // R6: interrupt timing
    tag = "R6";
    do_write(3'd2, 32'h0000_0001);
    addr = 3'd0; evt_norm = 5'h01; step();
    do_read(3'd0);
    do_write(3'd0, 32'h0000_0001);
    do_read(3'd0);

    // R7: set/clear of signal-enable
    tag = "R7";
    do_write(3'd3, 32'h0004_0002);
    do_write(3'd4, 32'h0000_0001);
    do_read(3'd2);
    do_write(3'd2, 32'h0000_0000);
    do_read(3'd4);

    // R8: mask independence
    tag = "R8";
    addr = 3'd0; evt_norm = 5'h08; step();
    do_write(3'd1, 32'h0000_0000);
    do_write(3'd3, 32'h0000_0008);
    do_read(3'd0);
    do_read(3'd0);
    do_write(3'd0, 32'hFFFF_FFFF);
    do_write(3'd1, 32'hFFFF_FFFF);

    // R9: stop-command error field
    tag = "R9";
    addr = 3'd5; acmd = 8'hA5; step();
    do_write(3'd5, 32'h0000_0081);
    acmd = 8'h02; do_write(3'd5, 32'h0000_00FF);
    do_write(3'd5, 32'h0000_00FF);

    // R4: random traffic with collisions
    tag = "R4";
    for (int n = 0; n < 600; n++) begin
      evt_norm = NW'($urandom) & NW'($urandom);
      evt_err  = EW'($urandom) & EW'($urandom) & EW'($urandom);
      acmd     = 8'($urandom) & 8'($urandom) & 8'($urandom);
      addr     = 3'($urandom);
      wdata    = $urandom;
      wr       = ($urandom_range(0, 3) == 0);
      step();
    end

    done = 1'b1;
    summary();
  end
endmodule